// File: doc/BRIEF.md
# Power-Good Deglitch Monitor

This block turns a set of digital comparator flags from a voltage regulator into the drive for an open-drain power-good pin. Analog comparators supply three flags: feedback above an upper threshold, feedback below a lower threshold, and reference high enough. The gap between the two feedback thresholds gives the output hysteresis. The block decides whether the regulator output is good. It presents the result as a pull-down enable: high means the pin is pulled low, and low means the pin is released to high impedance.

A change in either direction takes effect only after its triggering condition has held without a break for a fixed number of switching-clock ticks. Any break clears the pending count. Three system states force the pin low at once, without waiting for any count: shutdown, supply undervoltage lockout and thermal shutdown. After a forced-low period or a reset, the block starts in the pulled-low state and must requalify from zero.

Top module: `pgood_monitor`

## Requirements
- R1: The pin is released (`pullLow`=0) only after `fbAboveHi`=1, `fbBelowLo`=0 and `refOk`=1 have all held together across DEGLITCH_CYCLES (default 48) consecutive `swTick` pulses. With `refOk`=0 it never releases.
- R2: While released, the pin returns to pulled low (`pullLow`=1) after `fbBelowLo`=1 or `refOk`=0 has held across DEGLITCH_CYCLES consecutive `swTick` pulses.
- R3: A transition happens on the clock edge of the DEGLITCH_CYCLES-th qualifying tick, and not earlier. After DEGLITCH_CYCLES-1 ticks the output is unchanged.
- R4: While `shutdown`, `uvlo` or `thermalTrip` is 1, `pullLow` is 1 in the same cycle, combinationally, whatever the count.
- R5: With feedback inside the hysteresis band (`fbAboveHi`=0, `fbBelowLo`=0, `refOk`=1), the output keeps its current state for any number of ticks, and any pending count is cleared.
- R6: If the condition being counted lapses for even one clock before the count completes, the count restarts from zero. A full DEGLITCH_CYCLES run is then needed again.
- R7: After reset, and after any forced-low period ends, the output is pulled low. It releases only after a complete fresh qualification count.
- R8: Only clock cycles with `swTick`=1 advance the count. Cycles without a tick neither advance it nor clear it while the condition holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swTick | input | 1 | One-cycle pulse per switching period |
| fbAboveHi | input | 1 | Feedback above the upper (release) threshold |
| fbBelowLo | input | 1 | Feedback below the lower (pull-down) threshold |
| refOk | input | 1 | Reference above its minimum level |
| shutdown | input | 1 | Regulator disabled |
| uvlo | input | 1 | Supply undervoltage lockout active |
| thermalTrip | input | 1 | Thermal shutdown active |
| pullLow | output | 1 | 1 = pin pulled low, 0 = pin high impedance |

## Verification
The case that is hardest to reach is a count that is one tick short of completion and is then broken: by a single-clock lapse of the condition, by a trip through the hysteresis band, or by an override. Only a run of exactly DEGLITCH_CYCLES-1 ticks shows that the count was truly discarded rather than paused. The stimulus therefore drives long tick bursts of a chosen length, inserts a one-clock disturbance, and then plays DEGLITCH_CYCLES-1 more ticks. It expects no change there and a change on the tick that follows.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

  typedef enum logic {
    PG_PULLED   = 1'b0,
    PG_RELEASED = 1'b1
  } pgState_t;

  typedef struct packed {
    logic inc;
    logic clr;
  } ctlStrobes_t;

endpackage

// File: rtl/pgood_count.sv
module pgood_count
  import pgood_pkg::*;
#(
  parameter int DEGLITCH_CYCLES = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  output logic        cntHit
);
  localparam int CNT_W = $clog2(DEGLITCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEGLITCH_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign cntHit = strobes.inc && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strobes.clr) cnt <= '0;
    else if (strobes.inc) cnt <= cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST); // R3

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> (cnt == '0)); // R6

endmodule

// File: rtl/pgood_ctrl.sv
module pgood_ctrl
  import pgood_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swTick,
  input  logic        fbAboveHi,
  input  logic        fbBelowLo,
  input  logic        refOk,
  input  logic        forceLow,
  input  logic        cntHit,
  output ctlStrobes_t strobes,
  output logic        isGood
);
  pgState_t st;
  pgState_t stNext;
  logic goodCond;
  logic badCond;
  logic qualify;

  assign goodCond = fbAboveHi & ~fbBelowLo & refOk;
  assign badCond  = fbBelowLo | ~refOk;
  assign qualify  = (st == PG_PULLED) ? goodCond : badCond;

  always_comb begin
    strobes.inc = qualify & swTick & ~forceLow;
    strobes.clr = ~qualify | forceLow | cntHit;
  end

  always_comb begin
    stNext = st;
    if (forceLow)    stNext = PG_PULLED;
    else if (cntHit) stNext = (st == PG_PULLED) ? PG_RELEASED : PG_PULLED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= PG_PULLED;
    else       st <= stNext;
  end

  assign isGood = (st == PG_RELEASED);

  AST_RELEASE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isGood) |-> $past(goodCond && swTick && !forceLow)); // R1

  AST_FALL_NEEDS_BAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isGood) |-> $past(badCond || forceLow)); // R2

  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!forceLow && !goodCond && !badCond) |=> $stable(isGood)); // R5

endmodule

// File: rtl/pgood_monitor.sv
module pgood_monitor
  import pgood_pkg::*;
#(
  parameter int DEGLITCH_CYCLES = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic swTick,
  input  logic fbAboveHi,
  input  logic fbBelowLo,
  input  logic refOk,
  input  logic shutdown,
  input  logic uvlo,
  input  logic thermalTrip,
  output logic pullLow
);
  ctlStrobes_t strobes;
  logic cntHit;
  logic isGood;
  logic forceLow;

  assign forceLow = shutdown | uvlo | thermalTrip;

  pgood_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .swTick    (swTick),
    .fbAboveHi (fbAboveHi),
    .fbBelowLo (fbBelowLo),
    .refOk     (refOk),
    .forceLow  (forceLow),
    .cntHit    (cntHit),
    .strobes   (strobes),
    .isGood    (isGood)
  );

  pgood_count #(.DEGLITCH_CYCLES(DEGLITCH_CYCLES)) u_count (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cntHit  (cntHit)
  );

  assign pullLow = forceLow | ~isGood;

  AST_OVERRIDE_RESETS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    forceLow |=> !isGood); // R4

  AST_OVERRIDE_BLOCKS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    forceLow |-> !strobes.inc); // R7

endmodule

// File: tb/tb_pgood_monitor.sv
module tb_pgood_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swTick = 1'b0;
  logic fbAboveHi = 1'b0;
  logic fbBelowLo = 1'b1;
  logic refOk = 1'b0;
  logic shutdown = 1'b0;
  logic uvlo = 1'b0;
  logic thermalTrip = 1'b0;
  logic pullLow;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic  exp;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  pgood_monitor dut (
    .clk(clk), .rstN(rstN), .swTick(swTick), .fbAboveHi(fbAboveHi),
    .fbBelowLo(fbBelowLo), .refOk(refOk), .shutdown(shutdown), .uvlo(uvlo),
    .thermalTrip(thermalTrip), .pullLow(pullLow)
  );

  // Monitor: compares each queued expectation just after the next edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        total++;
        if (pullLow !== it.exp) begin
          bad++;
          $display("FAIL %s: pullLow=%b expected=%b", it.tag, pullLow, it.exp);
        end
      end
    end
  end

  task automatic expect_out(input logic exp, input string tag);
    expQ.push_back('{exp: exp, tag: tag});
    @(negedge clk);
  endtask

  task automatic check_now(input logic exp, input string tag);
    #1;
    total++;
    if (pullLow !== exp) begin
      bad++;
      $display("FAIL %s: pullLow=%b expected=%b", tag, pullLow, exp);
    end
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    swTick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    swTick = 1'b0;
  endtask

  task automatic set_fb(input logic above, input logic below, input logic rok);
    fbAboveHi = above;
    fbBelowLo = below;
    refOk = rok;
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    expect_out(1'b1, "R7 reset state");
    rstN = 1'b1;
    @(negedge clk);

    // R1/R3/R8: qualify good; 47 ticks then idle cycles keep it low
    set_fb(1'b1, 1'b0, 1'b1);
    run_ticks(47);
    expect_out(1'b1, "R3 no release after 47 ticks");
    repeat (5) @(negedge clk);
    expect_out(1'b1, "R8 idle cycles do not advance");
    run_ticks(1);
    expect_out(1'b0, "R1 release on 48th tick");

    // R5: band holds released state
    set_fb(1'b0, 1'b0, 1'b1);
    run_ticks(60);
    expect_out(1'b0, "R5 band keeps released");

    // R5/R6: bad count broken by band, then restart
    set_fb(1'b0, 1'b1, 1'b1);
    run_ticks(30);
    set_fb(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    set_fb(1'b0, 1'b1, 1'b1);
    run_ticks(47);
    expect_out(1'b0, "R5 band cleared pending count");
    run_ticks(1);
    expect_out(1'b1, "R2 pull low after 48 bad ticks");

    // R1: reference too low prevents release
    set_fb(1'b1, 1'b0, 1'b0);
    run_ticks(100);
    expect_out(1'b1, "R1 no release without refOk");

    // R6: one-clock lapse restarts count
    set_fb(1'b1, 1'b0, 1'b1);
    run_ticks(40);
    set_fb(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    set_fb(1'b1, 1'b0, 1'b1);
    run_ticks(47);
    expect_out(1'b1, "R6 lapse restarted count");
    run_ticks(1);
    expect_out(1'b0, "R6 release after full recount");

    // R2: reference drop pulls low
    set_fb(1'b1, 1'b0, 1'b0);
    run_ticks(47);
    expect_out(1'b0, "R3 no fall after 47 ticks");
    run_ticks(1);
    expect_out(1'b1, "R2 pull low on refOk loss");
    set_fb(1'b1, 1'b0, 1'b1);
    run_ticks(48);
    expect_out(1'b0, "R1 release again");

    // R4: overrides act combinationally
    shutdown = 1'b1;
    check_now(1'b1, "R4 shutdown forces low");
    @(negedge clk);
    shutdown = 1'b0;
    uvlo = 1'b1;
    check_now(1'b1, "R4 uvlo forces low");
    @(negedge clk);
    uvlo = 1'b0;
    thermalTrip = 1'b1;
    check_now(1'b1, "R4 thermal forces low");
    run_ticks(60);
    expect_out(1'b1, "R4 ticks during override ignored");
    thermalTrip = 1'b0;
    check_now(1'b1, "R7 still low after override ends");

    // R7: full requalification after override
    run_ticks(47);
    expect_out(1'b1, "R7 no release after 47 ticks");
    run_ticks(1);
    expect_out(1'b0, "R7 release after full count");

    // R4: override cancels a nearly complete bad count, state forced low
    set_fb(1'b0, 1'b1, 1'b1);
    run_ticks(47);
    uvlo = 1'b1;
    check_now(1'b1, "R4 override mid-count");
    @(negedge clk);
    uvlo = 1'b0;
    set_fb(1'b1, 1'b0, 1'b1);
    run_ticks(47);
    expect_out(1'b1, "R7 recount from zero after override");
    run_ticks(1);
    expect_out(1'b0, "R7 release after recount");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule